// File: doc/BRIEF.md
# Receive Checksum Offload Engine

This block sits in a receive byte stream between the frame receiver and the DMA engine. It looks at each Ethernet frame as it flows past and works out where the layer-3 payload begins. It skips the two 6-byte address fields, at most two 802.1Q tags (tag protocol 0x8100), and a length field. When the length field is followed by an LLC/SNAP header, it also skips that header. It then folds the payload bytes into a 16-bit ones'-complement sum and appends that sum to the frame as two extra bytes. The frame length it reports at end-of-frame grows by two.

Bytes enter on a valid/ready interface that carries start-of-frame and end-of-frame markers. They leave one cycle later on a valid-only interface with the same markers, plus a frame length that is valid alongside the end marker. The last four bytes of every frame are treated as the FCS and are never summed. Two static inputs control the block, and both must only change while no frame is in flight. The first turns the whole function on or off. The second picks between encapsulation-aware parsing and a fixed start point.

Top module: `rxcoe_top`

## Requirements
- R1: When enabled, every input byte appears on the output in order and unchanged, one cycle after it is accepted. `out_sof` marks the first byte of each frame.
- R2: The checksum is the 16-bit ones'-complement sum, with end-around carry, of the covered bytes paired into big-endian words. The first covered byte is a high byte, and an odd last byte is padded with a zero low byte. The final 4 bytes of the frame are never covered.
- R3: In mode 0 (`cfg_mode`=0), a type/length value of 0x0600 or above ends parsing, and coverage starts at the next byte. For an untagged frame that byte is offset 14.
- R4: In mode 0, a type value of 0x8100 is skipped together with its 2-byte tag control field, at most twice. A third 0x8100 counts as an ordinary type, and coverage starts right after it.
- R5: In mode 0, a value below 0x0600 followed by the bytes 0xAA, 0xAA, 0x03 is an LLC/SNAP header. The 3-byte OUI and 2-byte protocol id are skipped too, and coverage starts right after the protocol id. Tags before the length field are allowed.
- R6: In mode 0, a value below 0x0600 that is not followed by 0xAA 0xAA 0x03 starts coverage at the byte right after the length field.
- R7: In mode 1, coverage starts at frame offset 14 whatever the frame holds.
- R8: When enabled, two bytes follow the last frame byte: the checksum high byte, then the low byte. `out_eof` is set only on the low byte, with `out_len` equal to the input byte count plus 2.
- R9: When enabled, `in_ready` is low for exactly the two cycles after an end-of-frame byte is accepted, and high otherwise.
- R10: With `cfg_en` low, frames pass unchanged with no added bytes. `out_eof` is on the last input byte, `out_len` equals the input count, and `in_ready` stays high.
- R11: A frame that ends before its coverage start point (or whose covered range is empty) gets 0x0000 appended.
- R12: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | 1: append checksum; 0: transparent |
| cfg_mode | input | 1 | 0: parsed start; 1: fixed start at offset 14 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame |
| out_len | output | LEN_W | Frame length in bytes, valid with out_eof |

## Verification
The two functions that can land in the same cycle are the checksum append stall and the arrival of the next frame's start byte. The bench provokes this by driving back-to-back frames, so a start-of-frame byte is presented on the very cycle the previous frame's checksum high byte leaves. The scoreboard then requires both checksum bytes to come out before that start byte, with values that depend only on the earlier frame. The new frame's own checksum must also match, which shows the sum was cleared and not mixed with the old one. A second overlap happens inside the sum itself. The cycle that decides a header is not LLC/SNAP also retroactively marks earlier bytes for coverage. Short payloads push that decision close to the point where bytes leave the FCS window.

// File: rtl/rxcoe_pkg.sv
package rxcoe_pkg;

  localparam int ADDR_FIELD_BYTES = 12;
  localparam int TCI_BYTES        = 2;
  localparam int LLC_BYTES        = 3;
  localparam int SNAP_TAIL_BYTES  = 5;
  localparam logic [15:0] VLAN_TPID      = 16'h8100;
  localparam logic [15:0] TYPE_MIN       = 16'h0600;
  localparam logic [7:0]  LLC_SAP_SNAP   = 8'hAA;
  localparam logic [7:0]  LLC_CTRL_UI    = 8'h03;

  typedef enum logic [2:0] {
    PS_ADDR, PS_TYPE_HI, PS_TYPE_LO, PS_TCI, PS_LLC, PS_SNAP, PS_BODY
  } parse_st_e;

  typedef enum logic [1:0] {
    OS_PASS, OS_CS_HI, OS_CS_LO
  } emit_st_e;

  typedef struct packed {
    logic       vld;
    logic       cov;
    logic [7:0] dat;
  } dly_ent_t;

  function automatic logic [15:0] csum_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/rxcoe_parse.sv
module rxcoe_parse
  import rxcoe_pkg::*;
#(
  parameter int MAX_TAGS    = 2,
  parameter int FIXED_START = 14,
  parameter int POS_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [7:0]       data,
  input  logic             mode,
  input  logic [POS_W-1:0] pos,
  output logic             cov,
  output logic             revise
);

  localparam int TAG_W = $clog2(MAX_TAGS + 1);
  localparam logic [POS_W-1:0] FIX_POS   = POS_W'(FIXED_START);
  localparam logic [3:0]       ADDR_LAST = 4'(ADDR_FIELD_BYTES - 1);
  localparam logic [3:0]       TCI_LAST  = 4'(TCI_BYTES - 1);
  localparam logic [3:0]       LLC_LAST  = 4'(LLC_BYTES - 1);
  localparam logic [3:0]       SNAP_LAST = 4'(SNAP_TAIL_BYTES - 1);
  localparam logic [TAG_W-1:0] TAG_MAX   = TAG_W'(MAX_TAGS);

  parse_st_e        st_q, st_n, cur_st;
  logic [3:0]       cnt_q, cnt_n, cur_cnt;
  logic [TAG_W-1:0] tags_q, tags_n, cur_tags;
  logic [7:0]       thi_q, thi_n;
  logic             snap_q, snap_n, cur_snap;
  logic             cov_m, rev_m, llc_match;
  logic [15:0]      tval;

  assign cur_st   = sof ? PS_ADDR : st_q;
  assign cur_cnt  = sof ? 4'd0 : cnt_q;
  assign cur_tags = sof ? '0 : tags_q;
  assign cur_snap = sof ? 1'b1 : snap_q;
  assign tval     = {thi_q, data};

  always_comb begin
    case (cur_cnt)
      4'd0:    llc_match = (data == LLC_SAP_SNAP);
      4'd1:    llc_match = (data == LLC_SAP_SNAP);
      default: llc_match = (data == LLC_CTRL_UI);
    endcase
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    tags_n = tags_q;
    thi_n  = thi_q;
    snap_n = snap_q;
    cov_m  = 1'b0;
    rev_m  = 1'b0;
    if (beat) begin
      st_n   = cur_st;
      cnt_n  = cur_cnt + 4'd1;
      tags_n = cur_tags;
      snap_n = cur_snap;
      case (cur_st)
        PS_ADDR: begin
          if (cur_cnt == ADDR_LAST) begin
            st_n  = PS_TYPE_HI;
            cnt_n = 4'd0;
          end
        end
        PS_TYPE_HI: begin
          thi_n = data;
          st_n  = PS_TYPE_LO;
        end
        PS_TYPE_LO: begin
          cnt_n = 4'd0;
          if (tval == VLAN_TPID && cur_tags < TAG_MAX) begin
            tags_n = cur_tags + TAG_W'(1);
            st_n   = PS_TCI;
          end else if (tval < TYPE_MIN) begin
            st_n   = PS_LLC;
            snap_n = 1'b1;
          end else begin
            st_n = PS_BODY;
          end
        end
        PS_TCI: begin
          if (cur_cnt == TCI_LAST) begin
            st_n  = PS_TYPE_HI;
            cnt_n = 4'd0;
          end
        end
        PS_LLC: begin
          snap_n = cur_snap & llc_match;
          if (cur_cnt == LLC_LAST) begin
            cnt_n = 4'd0;
            if (cur_snap & llc_match) begin
              st_n = PS_SNAP;
            end else begin
              st_n  = PS_BODY;
              cov_m = 1'b1;
              rev_m = 1'b1;
            end
          end
        end
        PS_SNAP: begin
          if (cur_cnt == SNAP_LAST) begin
            st_n  = PS_BODY;
            cnt_n = 4'd0;
          end
        end
        default: begin
          cov_m = 1'b1;
          cnt_n = cnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_ADDR;
      cnt_q  <= 4'd0;
      tags_q <= '0;
      thi_q  <= 8'd0;
      snap_q <= 1'b0;
    end else if (beat) begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      tags_q <= tags_n;
      thi_q  <= thi_n;
      snap_q <= snap_n;
    end
  end

  assign cov    = beat & (mode ? (pos >= FIX_POS) : cov_m);
  assign revise = beat & ~mode & rev_m;

  p_tag_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tags_q <= TAG_MAX);

  p_first_byte_uncovered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |-> !cov);

endmodule

// File: rtl/rxcoe_sum.sv
module rxcoe_sum
  import rxcoe_pkg::*;
#(
  parameter int FCS_BYTES = 4,
  parameter int REV_SPAN  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        sof,
  input  logic [7:0]  data,
  input  logic        cov,
  input  logic        revise,
  output logic [15:0] sum
);

  dly_ent_t [FCS_BYTES-1:0] line_q, line_n, base_line;
  logic [15:0] acc_q, acc_n, base_acc;
  logic        par_q, par_n, base_par;
  dly_ent_t    pop;

  assign base_line = sof ? '0 : line_q;
  assign base_acc  = sof ? 16'd0 : acc_q;
  assign base_par  = sof ? 1'b0 : par_q;
  assign pop       = base_line[FCS_BYTES-1];

  always_comb begin
    line_n = line_q;
    acc_n  = acc_q;
    par_n  = par_q;
    if (beat) begin
      acc_n = base_acc;
      par_n = base_par;
      if (pop.vld && pop.cov) begin
        acc_n = csum_add(base_acc, base_par ? {8'h00, pop.dat} : {pop.dat, 8'h00});
        par_n = ~base_par;
      end
      for (int i = FCS_BYTES - 1; i > 0; i--) begin
        line_n[i] = base_line[i-1];
      end
      for (int i = 1; i <= REV_SPAN; i++) begin
        if (revise && line_n[i].vld) line_n[i].cov = 1'b1;
      end
      line_n[0] = '{vld: 1'b1, cov: cov, dat: data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      acc_q  <= 16'd0;
      par_q  <= 1'b0;
    end else if (beat) begin
      line_q <= line_n;
      acc_q  <= acc_n;
      par_q  <= par_n;
    end
  end

  assign sum = acc_q;

  p_clear_on_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (acc_q == 16'd0 && !par_q));

endmodule

// File: rtl/rxcoe_emit.sv
module rxcoe_emit
  import rxcoe_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [15:0]      sum,
  output logic             in_ready,
  output logic             beat,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [LEN_W-1:0] out_len
);

  localparam logic [LEN_W-1:0] CS_EXTRA = LEN_W'(2);

  emit_st_e         st_q, st_n;
  logic [LEN_W-1:0] lenh_q, lenh_n;
  logic             ov_n, os_n, oe_n;
  logic [7:0]       od_n;
  logic [LEN_W-1:0] ol_n;

  assign in_ready = (st_q == OS_PASS);
  assign beat     = in_valid & in_ready;

  always_comb begin
    st_n   = st_q;
    lenh_n = lenh_q;
    ov_n   = 1'b0;
    od_n   = 8'd0;
    os_n   = 1'b0;
    oe_n   = 1'b0;
    ol_n   = '0;
    case (st_q)
      OS_PASS: begin
        if (beat) begin
          ov_n = 1'b1;
          od_n = in_data;
          os_n = in_sof;
          if (in_eof && !en) begin
            oe_n = 1'b1;
            ol_n = frame_len;
          end
          if (in_eof && en) begin
            st_n   = OS_CS_HI;
            lenh_n = frame_len + CS_EXTRA;
          end
        end
      end
      OS_CS_HI: begin
        ov_n = 1'b1;
        od_n = sum[15:8];
        st_n = OS_CS_LO;
      end
      default: begin
        ov_n = 1'b1;
        od_n = sum[7:0];
        oe_n = 1'b1;
        ol_n = lenh_q;
        st_n = OS_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= OS_PASS;
      lenh_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'd0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_len   <= '0;
    end else begin
      st_q      <= st_n;
      lenh_q    <= lenh_n;
      out_valid <= ov_n;
      out_data  <= od_n;
      out_sof   <= os_n;
      out_eof   <= oe_n;
      out_len   <= ol_n;
    end
  end

  p_sof_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  p_append_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_eof && en) |=> ##2 (out_valid && out_eof && out_len == $past(frame_len, 3) + CS_EXTRA));

  p_stall_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_eof && en) |=> !in_ready ##1 !in_ready ##1 in_ready);

  p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_eof && !en) |=> (out_eof && in_ready && out_len == $past(frame_len)));

endmodule

// File: rtl/rxcoe_top.sv
module rxcoe_top
  import rxcoe_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int MAX_TAGS    = 2,
  parameter int FCS_BYTES   = 4,
  parameter int FIXED_START = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [LEN_W-1:0] out_len
);

  localparam int REV_SPAN = LLC_BYTES - 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             beat, cov, revise;
  logic [LEN_W-1:0] cnt_q, pos, frame_len;
  logic [15:0]      sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pos       = in_sof ? '0 : cnt_q;
  assign frame_len = pos + LEN_W'(1);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cnt_q <= '0;
    else if (beat)   cnt_q <= frame_len;
  end

  rxcoe_parse #(
    .MAX_TAGS(MAX_TAGS), .FIXED_START(FIXED_START), .POS_W(LEN_W)
  ) parse_i (
    .clk(clk), .rst_n(rst_int_n), .beat(beat), .sof(in_sof), .data(in_data),
    .mode(cfg_mode), .pos(pos), .cov(cov), .revise(revise)
  );

  rxcoe_sum #(
    .FCS_BYTES(FCS_BYTES), .REV_SPAN(REV_SPAN)
  ) sum_i (
    .clk(clk), .rst_n(rst_int_n), .beat(beat), .sof(in_sof), .data(in_data),
    .cov(cov), .revise(revise), .sum(sum)
  );

  rxcoe_emit #(
    .LEN_W(LEN_W)
  ) emit_i (
    .clk(clk), .rst_n(rst_int_n), .en(cfg_en), .in_valid(in_valid),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .frame_len(frame_len),
    .sum(sum), .in_ready(in_ready), .beat(beat), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_len(out_len)
  );

  p_reset_idle_r12: assert property (@(posedge clk)
    (!rst_int_n) |-> (in_ready && !out_valid));

endmodule

// File: tb/rxcoe_top_tb_top.sv
module rxcoe_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b1;
  logic        cfg_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        in_ready, out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic [15:0] out_len;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  d;
    logic        s;
    logic        e;
    logic [15:0] l;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] fr[$];

  always #4 clk = ~clk;

  rxcoe_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_len(out_len)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected output byte", out_data, 0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check(out_data == x.d && out_sof == x.s && out_eof == x.e &&
              (!x.e || out_len == x.l), x.tag, "byte/sof/eof/len",
              {out_sof, out_eof, out_data, out_len}, {x.s, x.e, x.d, x.l});
      end
    end
  end

  function automatic int start_of(input logic [7:0] f[$], input bit mode);
    int n = f.size();
    int p = 12;
    int v = 0;
    int t;
    if (mode) return 14;
    forever begin
      if (p + 1 >= n) return n;
      t = {f[p], f[p+1]};
      if (t == 16'h8100 && v < 2) begin
        v++;
        p += 4;
      end else begin
        p += 2;
        if (t < 16'h0600 && p + 2 < n && f[p] == 8'hAA && f[p+1] == 8'hAA && f[p+2] == 8'h03)
          return p + 8;
        return p;
      end
    end
  endfunction

  function automatic logic [15:0] model_sum(input logic [7:0] f[$], input bit mode);
    int s = start_of(f, mode);
    int acc = 0;
    int k = 0;
    for (int i = s; i < f.size() - 4; i++) begin
      acc += (k % 2 == 0) ? (int'(f[i]) << 8) : int'(f[i]);
      acc = (acc & 16'hFFFF) + (acc >> 16);
      k++;
    end
    return 16'(acc);
  endfunction

  task automatic f_new();
    fr.delete();
    for (int i = 0; i < 12; i++) fr.push_back(8'(8'h10 + i));
  endtask

  task automatic f_16(input logic [15:0] v);
    fr.push_back(v[15:8]);
    fr.push_back(v[7:0]);
  endtask

  task automatic f_pay(input int n, input int seed);
    for (int i = 0; i < n; i++) fr.push_back(8'(seed + i * 37));
  endtask

  task automatic send(input string tag, input bit chk_stall);
    int n = fr.size();
    logic [15:0] cs;
    exp_t x;
    cs = model_sum(fr, cfg_mode);
    for (int i = 0; i < n; i++) begin
      x.d = fr[i]; x.s = (i == 0); x.e = (!cfg_en && i == n - 1);
      x.l = 16'(n); x.tag = tag;
      exp_q.push_back(x);
    end
    if (cfg_en) begin
      x.d = cs[15:8]; x.s = 1'b0; x.e = 1'b0; x.l = 16'd0; x.tag = tag;
      exp_q.push_back(x);
      x.d = cs[7:0]; x.e = 1'b1; x.l = 16'(n + 2);
      exp_q.push_back(x);
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    if (chk_stall) begin
      if (cfg_en) begin
        check(!in_ready, "R9", "ready low cycle 1", in_ready, 0);
        @(negedge clk);
        check(!in_ready, "R9", "ready low cycle 2", in_ready, 0);
        @(negedge clk);
        check(in_ready, "R9", "ready back high", in_ready, 1);
      end else begin
        check(in_ready, "R10", "ready stays high", in_ready, 1);
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R12", "reset idle", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && in_ready, "R12", "after reset idle", {out_valid, in_ready}, 1);

    // R3, R2: untagged IPv4 type, odd payload length, pads low byte
    f_new(); f_16(16'h0800); f_pay(21, 3); f_pay(4, 200);
    send("R3", 1'b1); drain();
    // R4: one tag
    f_new(); f_16(16'h8100); f_16(16'h0005); f_16(16'h0800); f_pay(18, 9); f_pay(4, 1);
    send("R4", 1'b1); drain();
    // R4: two tags
    f_new(); f_16(16'h8100); f_16(16'h0006); f_16(16'h8100); f_16(16'h0007);
    f_16(16'h86DD); f_pay(16, 77); f_pay(4, 5);
    send("R4", 1'b1); drain();
    // R4: third tag treated as type
    f_new(); f_16(16'h8100); f_16(16'h0001); f_16(16'h8100); f_16(16'h0002);
    f_16(16'h8100); f_16(16'hABCD); f_pay(15, 4); f_pay(4, 8);
    send("R4", 1'b1); drain();
    // R5: LLC/SNAP untagged
    f_new(); f_16(16'h0030); fr.push_back(8'hAA); fr.push_back(8'hAA); fr.push_back(8'h03);
    f_pay(3, 0); f_16(16'h0800); f_pay(20, 50); f_pay(4, 2);
    send("R5", 1'b1); drain();
    // R5: LLC/SNAP behind two tags
    f_new(); f_16(16'h8100); f_16(16'h0009); f_16(16'h8100); f_16(16'h000A);
    f_16(16'h0040); fr.push_back(8'hAA); fr.push_back(8'hAA); fr.push_back(8'h03);
    f_pay(3, 90); f_16(16'h0806); f_pay(13, 11); f_pay(4, 6);
    send("R5", 1'b1); drain();
    // R6: length field, not SNAP
    f_new(); f_16(16'h0020); fr.push_back(8'hAA); fr.push_back(8'hAA); fr.push_back(8'h00);
    f_pay(11, 31); f_pay(4, 3);
    send("R6", 1'b1); drain();
    // R6: short non-SNAP body so the decision is near the FCS window
    f_new(); f_16(16'h0010); fr.push_back(8'h42); fr.push_back(8'h43); fr.push_back(8'h44);
    f_pay(1, 12); f_pay(4, 3);
    send("R6", 1'b1); drain();
    // R2: all-ones payload forces end-around carry
    f_new(); f_16(16'h0800); for (int i = 0; i < 30; i++) fr.push_back(8'hFF); f_pay(4, 9);
    send("R2", 1'b1); drain();
    // R11: frame ends inside addresses, and one ending inside the SNAP header
    f_new(); fr.delete(); f_pay(10, 1);
    send("R11", 1'b1); drain();
    f_new(); f_16(16'h0040); fr.push_back(8'hAA); fr.push_back(8'hAA); fr.push_back(8'h03);
    f_pay(4, 7);
    send("R11", 1'b1); drain();
    // R7: fixed start with a tagged frame
    cfg_mode = 1'b1; repeat (2) @(negedge clk);
    f_new(); f_16(16'h8100); f_16(16'h0003); f_16(16'h0800); f_pay(17, 21); f_pay(4, 4);
    send("R7", 1'b1); drain();
    cfg_mode = 1'b0; repeat (2) @(negedge clk);
    // R8, R1: back-to-back frames, next SOF meets the append stall
    f_new(); f_16(16'h0800); f_pay(9, 61); f_pay(4, 1);
    send("R8", 1'b0);
    f_new(); f_16(16'h0800); f_pay(12, 99); f_pay(4, 2);
    send("R1", 1'b0);
    f_new(); f_16(16'h8100); f_16(16'h0004); f_16(16'h0800); f_pay(8, 13); f_pay(4, 3);
    send("R8", 1'b1); drain();
    // R10: disabled, transparent
    cfg_en = 1'b0; repeat (2) @(negedge clk);
    f_new(); f_16(16'h0800); f_pay(15, 44); f_pay(4, 7);
    send("R10", 1'b1);
    f_new(); f_16(16'h0030); fr.push_back(8'hAA); fr.push_back(8'hAA); fr.push_back(8'h03);
    f_pay(9, 1); f_pay(4, 7);
    send("R10", 1'b1); drain();

    check(exp_q.size() == 0, "R1", "scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule